// File: doc/BRIEF.md
# Byte-Wide Synchronous Serial Controller (Master or Slave)

This block moves one byte at a time over a three-wire synchronous serial link (SCK, MOSI, MISO) plus an active-low select input. The same logic works as the clock-owning side (master) or as the clocked side (slave), and every byte is full-duplex: as each outgoing bit leaves on one data line, an incoming bit is taken from the other. In master mode the serial clock is produced from the system clock by one of four dividers. In slave mode the serial clock and the select line come in from outside.

Software uses a small register port with three locations: control, status and data. Writing the data location while idle loads the outgoing byte and, in master mode, starts the transfer. The byte just received goes to a separate read buffer, so it can be read while the next byte shifts. Two sticky flags report a completed byte and a data write that arrived mid-transfer. The completion flag also drives the interrupt request.

Top module: `spi_port_ctrl`

## Requirements
- R1: After reset the control, status and data locations all read 0, irq is 0, and sck_o, sck_oe, mosi_oe and miso_oe are all 0.
- R2: With master mode enabled, a data write while idle starts a transfer. SCK rests low and gives exactly 8 high pulses. Each SCK level lasts H system clocks, where H is 2, 8, 32 or 64 for rate codes 0, 1, 2 and 3 (dividers of 4, 16, 64 and 128). The first rising SCK edge comes H clocks after the write is taken.
- R3: Control bit 2 selects the bit order: 0 sends and receives the most significant bit first, and 1 sends and receives the least significant bit first.
- R4: Outgoing bits change on falling SCK edges, and the first bit is valid from the load. Incoming bits are sampled on rising edges. When the byte completes, the gathered byte appears at the data location (address 2).
- R5: Status bit 0 shows a transfer in progress. The cycle busy drops at the end of a byte, status bit 7 (done) becomes 1 and irq becomes 1.
- R6: A data write while busy sets status bit 6 (collision). The write is discarded and the bits still to be shifted are unchanged.
- R7: Both flags clear only after a status read that happens while a flag is set, followed by an access to the data location. A data access with no such status read first leaves both flags set.
- R8: In slave mode (control bit 1 = 0, bit 0 = 1), SCK comes from sck_i. miso_oe is 1 only while ss_n_i is low, and the outgoing bits follow R3 and R4.
- R9: In slave mode, taking ss_n_i high aborts a partly shifted byte. Busy clears, no completion is flagged, and the next byte starts again from its first bit.
- R10: With control bit 0 (enable) at 0, a data write starts nothing: sck_o and sck_oe stay 0 and busy stays 0.
- R11: The control location (address 0) reads back the full byte last written. Bit 0 is enable, bit 1 is master, bit 2 is LSB-first, and bits 4:3 are the rate code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (drives the flag-clear sequence) |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr, combinational |
| irq | output | 1 | Interrupt request, equal to the done flag |
| sck_i | input | 1 | Serial clock input (slave mode) |
| sck_o | output | 1 | Serial clock output (master mode) |
| sck_oe | output | 1 | Drive enable for sck_o |
| ss_n_i | input | 1 | Active-low select (slave mode) |
| mosi_i | input | 1 | Serial data in (slave mode) |
| mosi_o | output | 1 | Serial data out (master mode) |
| mosi_oe | output | 1 | Drive enable for mosi_o |
| miso_i | input | 1 | Serial data in (master mode) |
| miso_o | output | 1 | Serial data out (slave mode) |
| miso_oe | output | 1 | Drive enable for miso_o (slave selected) |

## Verification
In master mode, each result is due a fixed number of clocks after the edge that takes the data write. The first bit is on mosi_o at once, SCK toggles after every H clocks, and busy, done and irq change together 16·H clocks after the write. The reference model counts clocks from that edge and compares SCK, MOSI, busy and irq at every falling clock edge. In slave mode, each sck_i edge is acted on at the first rising clock edge after it changes, so the bench holds each SCK level for three clocks and samples miso_o and the registers only after that margin. Flag and readback results are sampled one clock after the register access that causes them.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

  // Register locations
  typedef enum logic [1:0] {
    LOC_CTRL = 2'd0,
    LOC_STAT = 2'd1,
    LOC_DATA = 2'd2
  } loc_e;

  // Control field positions
  localparam int CB_EN   = 0;
  localparam int CB_MST  = 1;
  localparam int CB_LSB  = 2;
  localparam int CB_RATE = 3;   // two bits: CB_RATE+1:CB_RATE

  // Longest SCK level, in system clocks, and the counter that spans it
  localparam int MAX_HALF = 64;
  localparam int HALF_W   = $clog2(MAX_HALF);

  // System clocks per SCK level for each rate code (divider / 2)
  function automatic int unsigned half_period(input logic [1:0] rate);
    case (rate)
      2'd0:    return 2;
      2'd1:    return 8;
      2'd2:    return 32;
      default: return 64;
    endcase
  endfunction

endpackage

// File: rtl/spi_sck_gen.sv
module spi_sck_gen
  import spi_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] rate,
  output logic       sck,
  output logic       edge_rise,
  output logic       edge_fall
);
  logic [HALF_W-1:0] cnt;
  logic              tick;

  assign tick      = run && (cnt == HALF_W'(half_period(rate) - 1));
  assign edge_rise = tick & ~sck;
  assign edge_fall = tick & sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      sck <= ~sck;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int DW = 8,
  localparam int CW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lsb_first,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          start,
  input  logic          sample,
  input  logic          shift,
  input  logic          abort,
  input  logic          rx_in,
  output logic          busy,
  output logic          tx_bit,
  output logic          done,
  output logic [CW-1:0] bit_cnt,
  output logic [DW-1:0] rx_buf
);
  logic [DW-1:0] sreg;
  logic [DW-1:0] nxt;
  logic          in_q;
  logic          shift_ok;

  assign shift_ok = shift & busy;
  assign done     = shift_ok && (bit_cnt == CW'(DW - 1));
  assign tx_bit   = lsb_first ? sreg[0] : sreg[DW-1];

  always_comb begin
    if (lsb_first) nxt = {in_q, sreg[DW-1:1]};
    else           nxt = {sreg[DW-2:0], in_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg    <= '0;
      in_q    <= 1'b0;
      busy    <= 1'b0;
      bit_cnt <= '0;
      rx_buf  <= '0;
    end else begin
      if (load)          sreg <= load_data;
      else if (shift_ok) sreg <= nxt;

      if (sample) in_q <= rx_in;

      if (abort || done) begin
        bit_cnt <= '0;
        busy    <= 1'b0;
      end else begin
        if (shift_ok)        bit_cnt <= bit_cnt + 1'b1;
        if (start || sample) busy    <= 1'b1;
      end

      if (done) rx_buf <= nxt;
    end
  end
endmodule

// File: rtl/spi_flag_unit.sv
module spi_flag_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_done,
  input  logic set_wcol,
  input  logic stat_rd,
  input  logic data_acc,
  output logic done_f,
  output logic wcol_f
);
  logic armed;
  logic clr;

  assign clr = data_acc & armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      done_f <= 1'b0;
      wcol_f <= 1'b0;
    end else begin
      done_f <= set_done | (done_f & ~clr);
      wcol_f <= set_wcol | (wcol_f & ~clr);
      if (stat_rd)       armed <= done_f | wcol_f;
      else if (data_acc) armed <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_port_ctrl.sv
module spi_port_ctrl
  import spi_port_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe,
  input  logic              ss_n_i,
  input  logic              mosi_i,
  output logic              mosi_o,
  output logic              mosi_oe,
  input  logic              miso_i,
  output logic              miso_o,
  output logic              miso_oe
);
  localparam int CW = $clog2(DATA_W);

  logic [DATA_W-1:0] ctrl_q;
  logic              en, mst, slave_on, lsb_first;
  logic [1:0]        rate;
  logic              data_wr, data_rd, stat_rd;
  logic              busy, tx_bit, xfer_done;
  logic [CW-1:0]     bit_cnt;
  logic [DATA_W-1:0] rx_buf;
  logic              m_rise, m_fall, s_rise, s_fall, sck_q;
  logic              done_f, wcol_f;
  logic              start, collide, abort, rx_in;

  // Control decode
  assign en        = ctrl_q[CB_EN];
  assign mst       = en & ctrl_q[CB_MST];
  assign slave_on  = en & ~ctrl_q[CB_MST];
  assign lsb_first = ctrl_q[CB_LSB];
  assign rate      = ctrl_q[CB_RATE+1:CB_RATE];

  // Register strobes
  assign data_wr = reg_wr && (reg_addr == LOC_DATA);
  assign data_rd = reg_rd && (reg_addr == LOC_DATA);
  assign stat_rd = reg_rd && (reg_addr == LOC_STAT);

  // Named events
  assign start   = data_wr & mst & ~busy;
  assign collide = data_wr & busy;
  assign abort   = ~en | (slave_on & ss_n_i);
  assign rx_in   = mst ? miso_i : mosi_i;
  assign s_rise  = slave_on & ~ss_n_i & sck_i & ~sck_q;
  assign s_fall  = slave_on & ~ss_n_i & ~sck_i & sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      sck_q  <= 1'b0;
    end else begin
      if (reg_wr && (reg_addr == LOC_CTRL)) ctrl_q <= reg_wdata;
      sck_q <= sck_i;
    end
  end

  spi_sck_gen u_sck (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (mst & busy),
    .rate      (rate),
    .sck       (sck_o),
    .edge_rise (m_rise),
    .edge_fall (m_fall)
  );

  spi_shift_core #(.DW(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .lsb_first (lsb_first),
    .load      (data_wr & ~busy),
    .load_data (reg_wdata),
    .start     (start),
    .sample    (m_rise | s_rise),
    .shift     (m_fall | s_fall),
    .abort     (abort),
    .rx_in     (rx_in),
    .busy      (busy),
    .tx_bit    (tx_bit),
    .done      (xfer_done),
    .bit_cnt   (bit_cnt),
    .rx_buf    (rx_buf)
  );

  spi_flag_unit u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_done (xfer_done),
    .set_wcol (collide),
    .stat_rd  (stat_rd),
    .data_acc (data_wr | data_rd),
    .done_f   (done_f),
    .wcol_f   (wcol_f)
  );

  // Pins
  assign irq     = done_f;
  assign sck_oe  = mst;
  assign mosi_oe = mst;
  assign mosi_o  = mst & tx_bit;
  assign miso_oe = slave_on & ~ss_n_i;
  assign miso_o  = slave_on & tx_bit;

  // Read mux
  always_comb begin
    reg_rdata = '0;
    case (loc_e'(reg_addr))
      LOC_CTRL: reg_rdata = ctrl_q;
      LOC_STAT: begin
        reg_rdata[DATA_W-1] = done_f;
        reg_rdata[DATA_W-2] = wcol_f;
        reg_rdata[0]        = busy;
      end
      LOC_DATA: reg_rdata = rx_buf;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_port_ctrl_chk.sv
module spi_port_ctrl_chk #(
  parameter int DATA_W = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      busy,
  input logic                      xfer_done,
  input logic                      irq,
  input logic                      wcol_f,
  input logic                      sck_o,
  input logic                      ss_n_i,
  input logic                      miso_oe,
  input logic                      slave_on,
  input logic [$clog2(DATA_W)-1:0] bit_cnt
);
  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck_o); // R2
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !busy); // R5
  AST_IRQ_FROM_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(xfer_done)); // R5
  AST_WCOL_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wcol_f) |-> $past(busy)); // R6
  AST_MISO_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    ss_n_i |-> !miso_oe); // R8
  AST_DESELECT_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_on && ss_n_i) |=> (bit_cnt == '0)); // R9
endmodule

bind spi_port_ctrl spi_port_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .xfer_done (xfer_done),
  .irq       (irq),
  .wcol_f    (wcol_f),
  .sck_o     (sck_o),
  .ss_n_i    (ss_n_i),
  .miso_oe   (miso_oe),
  .slave_on  (slave_on),
  .bit_cnt   (bit_cnt)
);

// File: tb/tb_spi_port_ctrl.sv
module tb_spi_port_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] reg_addr;
  logic       reg_wr, reg_rd;
  logic [7:0] reg_wdata, reg_rdata;
  logic       irq, sck_i, sck_o, sck_oe, ss_n_i;
  logic       mosi_i, mosi_o, mosi_oe, miso_i, miso_o, miso_oe;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  spi_port_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
    .ss_n_i(ss_n_i), .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic pick(input logic [7:0] v, input int k, input logic lsb);
    return lsb ? v[k] : v[7-k];
  endfunction

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0; reg_addr = 2'd1;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0; reg_addr = 2'd1;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a; #1 d = reg_rdata; reg_addr = 2'd1; #1;
  endtask

  // Read back and clear after a byte: R4 data, R7 sequence
  task automatic finish_byte(input logic [7:0] exp_rx, input logic exp_wcol);
    logic [7:0] d;
    bus_rd(2'd2, d);
    chk("R4 received byte", d, exp_rx);
    #1 chk("R7 flag kept without status read", irq, 1'b1);
    bus_rd(2'd1, d);
    chk("R5 done bit", d[7], 1'b1);
    chk("R6 collision bit", d[6], exp_wcol);
    bus_rd(2'd2, d);
    #1 chk("R7 irq cleared", irq, 1'b0);
    peek(2'd1, d);
    chk("R7 flags cleared", d[7:6], 2'b00);
  endtask

  task automatic master_run(input logic [1:0] rate, input logic lsb,
                            input logic [7:0] tx, input logic [7:0] pat, input int col_n);
    int h;
    int pulses;
    logic prev;
    h = 1;
    for (int i = 0; i <= int'(rate); i++) h = h * 4;
    if (rate == 2'd3) h = 128;
    h = h / 2;
    pulses = 0;
    prev = 1'b0;
    bus_wr(2'd0, {3'b000, rate, lsb, 1'b1, 1'b1});
    miso_i = pick(pat, 0, lsb);
    bus_wr(2'd2, tx);
    for (int n = 0; n <= 16*h + 2; n++) begin
      #1;
      chk("R2 sck level", sck_o, (n < 16*h) ? ((n / h) % 2) : 0);
      if (n < 16*h) chk("R3 mosi bit", mosi_o, pick(tx, n / (2*h), lsb));
      if (reg_addr == 2'd1) chk("R5 busy", reg_rdata[0], n < 16*h);
      chk("R5 irq", irq, n >= 16*h);
      if (sck_o && !prev) pulses++;
      prev = sck_o;
      miso_i = pick(pat, (n / (2*h)) & 7, lsb);
      if (n == col_n) begin
        reg_addr = 2'd2; reg_wdata = ~tx; reg_wr = 1'b1;
      end else begin
        reg_addr = 2'd1; reg_wr = 1'b0;
      end
      @(negedge clk);
    end
    chk("R2 pulse count", pulses, 8);
    chk("R2 sck drive", sck_oe, 1'b1);
  endtask

  task automatic slave_run(input logic lsb, input logic [7:0] tx,
                           input logic [7:0] pat, input int abort_at);
    logic [7:0] d;
    bit aborted;
    aborted = 1'b0;
    bus_wr(2'd0, {5'b00000, lsb, 1'b0, 1'b1});
    bus_wr(2'd2, tx);
    #1 chk("R8 miso released while deselected", miso_oe, 1'b0);
    @(negedge clk); ss_n_i = 1'b0;
    @(negedge clk); #1 chk("R8 miso driven when selected", miso_oe, 1'b1);
    for (int k = 0; k < 8; k++) begin
      if (k == abort_at) begin
        ss_n_i = 1'b1;
        repeat (3) @(negedge clk);
        #1 chk("R9 miso released on abort", miso_oe, 1'b0);
        peek(2'd1, d);
        chk("R9 busy cleared on abort", d[0], 1'b0);
        chk("R9 no completion on abort", irq, 1'b0);
        aborted = 1'b1;
        break;
      end
      chk("R8 slave miso bit", miso_o, pick(tx, k, lsb));
      mosi_i = pick(pat, k, lsb);
      repeat (3) @(negedge clk); sck_i = 1'b1;
      repeat (3) @(negedge clk); sck_i = 1'b0;
      repeat (3) @(negedge clk); #1;
    end
    if (!aborted) begin
      chk("R5 slave irq", irq, 1'b1);
      ss_n_i = 1'b1;
      finish_byte(pat, 1'b0);
    end
  endtask

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; reg_addr = 2'd1; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
    sck_i = 1'b0; ss_n_i = 1'b1; mosi_i = 1'b0; miso_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    peek(2'd0, d); chk("R1 control", d, 8'h00);
    peek(2'd1, d); chk("R1 status", d, 8'h00);
    peek(2'd2, d); chk("R1 data", d, 8'h00);
    chk("R1 irq", irq, 1'b0);
    chk("R1 pin enables", {sck_o, sck_oe, mosi_oe, miso_oe}, 4'b0000);

    // R11 control readback
    bus_wr(2'd0, 8'hE4);
    peek(2'd0, d); chk("R11 control readback", d, 8'hE4);

    // Master transfers across rates and both bit orders
    master_run(2'd0, 1'b0, 8'hA5, 8'h3C, -1);
    finish_byte(8'h3C, 1'b0);
    master_run(2'd1, 1'b1, 8'h81, 8'h6E, 40); // collision mid-byte (R6)
    finish_byte(8'h6E, 1'b1);
    master_run(2'd2, 1'b0, 8'h5B, 8'hC9, -1);
    finish_byte(8'hC9, 1'b0);
    master_run(2'd3, 1'b1, 8'h2D, 8'hF0, -1);
    finish_byte(8'hF0, 1'b0);

    // Slave: aborted byte, then full bytes in each order
    slave_run(1'b0, 8'hA5, 8'h3C, 3);
    slave_run(1'b1, 8'h96, 8'hC3, -1);
    slave_run(1'b0, 8'h4E, 8'h17, -1);

    // R10 disabled block
    bus_wr(2'd0, 8'h02);
    bus_wr(2'd2, 8'h55);
    repeat (20) @(negedge clk);
    #1 chk("R10 no sck when disabled", {sck_o, sck_oe}, 2'b00);
    peek(2'd1, d);
    chk("R10 not busy when disabled", d[0], 1'b0);
    chk("R10 no irq when disabled", irq, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule